// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Coder

This block turns the nibble stream that a MAC presents for 100 Mb/s transmission into the three-level line code for the cable. It owns the nibble timing itself. It counts symbol-bit enables, and on every fifth one it raises a request strobe and samples the data nibble, the frame-enable flag and the error flag in that same cycle.

Each sampled nibble becomes one 5-bit code group:

- While no frame is in progress, the block emits IDLE groups.
- When a frame opens, the first two nibbles (the first preamble octet) are replaced by the start delimiter pair.
- Later nibbles go through the 4B/5B data table, or become the error group when the error flag is set.
- When the enable drops, the block appends the end delimiter pair and then returns to IDLE.

The code group is shifted out most significant bit first. Each bit is XORed with the keystream of an 11-bit self-synchronising scrambler and then converted to MLT3. The whole path runs on one clock, qualified by the bit enable.

Top module: `fe_tx_coder`

## Requirements
- R1: With reset held low, the line output is the zero level (2'b00). The first nibble is sampled on the fifth bit enable after reset, and until then the bit enables carry an IDLE group (11111).
- R2: `nib_req` is high only in a cycle with `bit_en` high. It is high on every fifth bit enable and never on two consecutive cycles. The nibble inputs are sampled at the clock edge that ends that cycle.
- R3: The first nibble sampled with `mac_en` high while no frame is in progress is sent as J (11000). The next nibble is sent as K (10001), whatever its data or error flag.
- R4: After J and K, every nibble sampled with `mac_en` high and `mac_err` low is sent through the data table: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data-phase nibble sampled with `mac_en` high and `mac_err` high is sent as H (00100), whatever its data.
- R6: The first nibble sampled with `mac_en` low after the data phase is sent as T (01101). The following nibble is sent as R (00111), even if `mac_en` is high again, and the block is then idle.
- R7: Outside a frame every group is IDLE (11111). The data and error inputs are ignored there.
- R8: Each code group goes out most significant bit first, one bit per bit enable.
- R9: The scrambler is an 11-bit register seeded with `SCR_SEED` at reset. Its key bit is stage 11 XOR stage 9 (bits 10 and 8). It shifts the key into bit 0 on each bit enable, and the line bit is the code bit XOR the key.
- R10: `mlt3` encodes 0 as 2'b00, +1 as 2'b01 and −1 as 2'b11. A scrambled 1 steps it through the cycle 0, +1, 0, −1, and a scrambled 0 holds it.
- R11: In a cycle with `bit_en` low, the line output, the scrambler and the bit position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Symbol-bit enable, one line bit per enabled cycle |
| mac_nib | input | 4 | Transmit data nibble |
| mac_en | input | 1 | Frame in progress, from the MAC |
| mac_err | input | 1 | Transmit error flag, from the MAC |
| nib_req | output | 1 | Nibble inputs are sampled at the end of this cycle |
| mlt3 | output | 2 | Three-level line state |

## Verification
The bench builds the coder with a scrambler seed of 11'h5A3 instead of the all-ones default. A reference keystream that starts from the wrong state therefore shows up at once as wrong recovered groups. The bench recovers line bits from MLT3 transitions, descrambles them with that seed, and rebuilds the code groups. This lets it compare every group against an expected sequence, including the delimiters, the error group and a frame that restarts during the end delimiter. Runs with a gapped bit enable then expose any state that moves on a disabled cycle.

// File: rtl/fe_tx_coder.sv
module fe_tx_coder #(
  parameter int SCR_W = 11,
  parameter int SCR_TAP = 9,
  parameter logic [SCR_W-1:0] SCR_SEED = {SCR_W{1'b1}}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [3:0] mac_nib,
  input  logic       mac_en,
  input  logic       mac_err,
  output logic       nib_req,
  output logic [1:0] mlt3
);
  localparam int GRP_W = 5;
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(GRP_W - 1);

  localparam logic [GRP_W-1:0] G_J    = 5'b11000;
  localparam logic [GRP_W-1:0] G_K    = 5'b10001;
  localparam logic [GRP_W-1:0] G_T    = 5'b01101;
  localparam logic [GRP_W-1:0] G_R    = 5'b00111;
  localparam logic [GRP_W-1:0] G_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] G_H    = 5'b00100;

  typedef enum logic [1:0] {FR_IDLE, FR_K, FR_DATA, FR_R} fr_t;

  logic [CNT_W-1:0] bit_cnt;
  logic [GRP_W-1:0] grp_sh, grp_nx;
  fr_t              fr_st, fr_nx;
  logic [SCR_W-1:0] scr_q;
  logic [1:0]       mlt_ph;
  logic             scr_key, line_bit;

  function automatic logic [GRP_W-1:0] data_code(input logic [3:0] n);
    case (n)
      4'h0: data_code = 5'b11110;
      4'h1: data_code = 5'b01001;
      4'h2: data_code = 5'b10100;
      4'h3: data_code = 5'b10101;
      4'h4: data_code = 5'b01010;
      4'h5: data_code = 5'b01011;
      4'h6: data_code = 5'b01110;
      4'h7: data_code = 5'b01111;
      4'h8: data_code = 5'b10010;
      4'h9: data_code = 5'b10011;
      4'hA: data_code = 5'b10110;
      4'hB: data_code = 5'b10111;
      4'hC: data_code = 5'b11010;
      4'hD: data_code = 5'b11011;
      4'hE: data_code = 5'b11100;
      default: data_code = 5'b11101;
    endcase
  endfunction

  assign nib_req  = bit_en && (bit_cnt == LAST_BIT);
  assign scr_key  = scr_q[SCR_W-1] ^ scr_q[SCR_TAP-1];
  assign line_bit = grp_sh[GRP_W-1] ^ scr_key;

  always_comb begin
    fr_nx  = fr_st;
    grp_nx = G_IDLE;
    case (fr_st)
      FR_IDLE: if (mac_en) begin
        grp_nx = G_J;
        fr_nx  = FR_K;
      end
      FR_K: begin
        grp_nx = G_K;
        fr_nx  = FR_DATA;
      end
      FR_DATA: if (!mac_en) begin
        grp_nx = G_T;
        fr_nx  = FR_R;
      end else begin
        grp_nx = mac_err ? G_H : data_code(mac_nib);
      end
      default: begin
        grp_nx = G_R;
        fr_nx  = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      grp_sh  <= G_IDLE;
      fr_st   <= FR_IDLE;
      scr_q   <= SCR_SEED;
      mlt_ph  <= 2'd0;
    end else if (bit_en) begin
      scr_q <= {scr_q[SCR_W-2:0], scr_key};
      if (line_bit) mlt_ph <= mlt_ph + 2'd1;
      if (nib_req) begin
        bit_cnt <= '0;
        grp_sh  <= grp_nx;
        fr_st   <= fr_nx;
      end else begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        grp_sh  <= {grp_sh[GRP_W-2:0], 1'b0};
      end
    end
  end

  assign mlt3 = (mlt_ph == 2'd1) ? 2'b01 :
                (mlt_ph == 2'd3) ? 2'b11 : 2'b00;
endmodule

// File: rtl/fe_tx_coder_chk.sv
module fe_tx_coder_chk #(
  parameter int SCR_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             nib_req,
  input logic [1:0]       mlt3,
  input logic [SCR_W-1:0] scr_state
);
  // R10
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mlt3 != 2'b10);

  // R10
  from_plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt3 == 2'b01) |=> (mlt3 == 2'b01 || mlt3 == 2'b00));

  // R10
  from_minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt3 == 2'b11) |=> (mlt3 == 2'b11 || mlt3 == 2'b00));

  // R11
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(mlt3));

  // R11
  hold_scr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(scr_state));

  // R2
  req_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_req |-> bit_en);

  // R2
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_req |=> !nib_req);
endmodule

bind fe_tx_coder fe_tx_coder_chk #(.SCR_W(SCR_W)) chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nib_req(nib_req),
  .mlt3(mlt3), .scr_state(scr_q)
);

// File: tb/fe_tx_coder_test.sv
module fe_tx_coder_test;
  localparam logic [10:0] SEED = 11'h5A3;
  localparam logic [4:0] G_J = 5'b11000, G_K = 5'b10001, G_T = 5'b01101,
                         G_R = 5'b00111, G_I = 5'b11111, G_H = 5'b00100;
  localparam logic [8:0] VEC [16] = '{
    {4'h0, 5'b11110}, {4'h1, 5'b01001}, {4'h2, 5'b10100}, {4'h3, 5'b10101},
    {4'h4, 5'b01010}, {4'h5, 5'b01011}, {4'h6, 5'b01110}, {4'h7, 5'b01111},
    {4'h8, 5'b10010}, {4'h9, 5'b10011}, {4'hA, 5'b10110}, {4'hB, 5'b10111},
    {4'hC, 5'b11010}, {4'hD, 5'b11011}, {4'hE, 5'b11100}, {4'hF, 5'b11101}};

  logic clk = 0, rst_n = 0, bit_en = 0, mac_en = 0, mac_err = 0;
  logic [3:0] mac_nib = 0;
  logic nib_req;
  logic [1:0] mlt3;

  fe_tx_coder #(.SCR_SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mac_nib(mac_nib),
    .mac_en(mac_en), .mac_err(mac_err), .nib_req(nib_req), .mlt3(mlt3));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit gap_mode = 0, gap_ph = 0;
  logic [10:0] rl = SEED;
  logic [1:0] prev_m = 2'b00, ref_ph = 0;
  logic [4:0] acc = 0;
  int nbits = 0, ng = 0, ne = 1, en_total = 0, bst = 0;
  logic [4:0] grp [0:511];
  logic [4:0] expg [0:511];
  string etag [0:511];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lvl(input logic [1:0] p);
    return (p == 1) ? 2'b01 : (p == 3) ? 2'b11 : 2'b00;
  endfunction

  task automatic record_bit();
    logic lb, key, plain;
    lb = (mlt3 != prev_m);
    if (lb) ref_ph = ref_ph + 1;
    if (mlt3 != lvl(ref_ph)) chk(0, "R10 mlt3 step", mlt3, lvl(ref_ph));
    key = rl[10] ^ rl[8];
    rl = {rl[9:0], key};
    plain = lb ^ key;
    acc = {acc[3:0], plain};
    nbits++;
    if (nbits % 5 == 0) begin
      grp[ng] = acc;
      ng++;
    end
    prev_m = mlt3;
  endtask

  task automatic tick(output bit took);
    bit be;
    @(negedge clk);
    if (gap_mode) begin gap_ph = ~gap_ph; bit_en = gap_ph; end
    else bit_en = 1;
    #1;
    took = nib_req;
    be = bit_en;
    if (nib_req && !bit_en) chk(0, "R2 req without enable", 1, 0);
    @(posedge clk);
    #1;
    if (be) begin
      en_total++;
      record_bit();
    end else if (mlt3 != prev_m) chk(0, "R11 hold", mlt3, prev_m);
    if (took) chk(en_total % 5 == 0, "R2 request spacing", en_total % 5, 0);
  endtask

  task automatic send_nib(input bit en, input bit er, input logic [3:0] d);
    bit took;
    logic [4:0] g;
    string t;
    mac_en = en; mac_err = er; mac_nib = d;
    took = 0;
    while (!took) tick(took);
    case (bst)
      0: if (en) begin g = G_J; t = "R3 J"; bst = 1; end
         else begin g = G_I; t = "R7 idle"; end
      1: begin g = G_K; t = "R3 K"; bst = 2; end
      2: if (!en) begin g = G_T; t = "R6 T"; bst = 3; end
         else if (er) begin g = G_H; t = "R5 H"; end
         else begin g = VEC[d][4:0]; t = "R4 data"; end
      default: begin g = G_R; t = "R6 R"; bst = 0; end
    endcase
    expg[ne] = g; etag[ne] = t; ne++;
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    expg[0] = G_I; etag[0] = "R1 reset idle";
    repeat (4) @(posedge clk);
    #1;
    chk(mlt3 == 2'b00, "R1 reset level", mlt3, 0);
    chk(nib_req == 0, "R1 no request in reset", nib_req, 0);
    @(negedge clk); rst_n = 1;
    // R11: disabled cycles right after reset
    repeat (3) begin
      @(posedge clk); #1;
      chk(mlt3 == 2'b00, "R11 idle hold", mlt3, 0);
    end
    // R7: data and error ignored outside a frame
    send_nib(0, 1, 4'hA);
    send_nib(0, 0, 4'h3);
    send_nib(0, 1, 4'h0);
    // R3 R4 R8 R9: full frame through the vector table
    send_nib(1, 0, 4'h5);
    send_nib(1, 1, 4'h0);
    for (int i = 0; i < 12; i++) send_nib(1, 0, 4'h5);
    send_nib(1, 0, 4'hD);
    for (int i = 0; i < 16; i++) send_nib(1, 0, VEC[i][8:5]);
    send_nib(1, 1, 4'h7);
    send_nib(0, 0, 4'h0);
    send_nib(0, 1, 4'h0);
    send_nib(0, 0, 4'h0);
    // R11 gapped enable, R6 restart during end delimiter
    gap_mode = 1;
    send_nib(1, 0, 4'h5);
    send_nib(1, 0, 4'h5);
    send_nib(1, 0, 4'hD);
    send_nib(1, 0, 4'h9);
    send_nib(0, 0, 4'h0);
    send_nib(1, 0, 4'h4);
    send_nib(1, 0, 4'h5);
    send_nib(1, 0, 4'h5);
    send_nib(1, 1, 4'h2);
    send_nib(1, 0, 4'hE);
    send_nib(0, 0, 4'h0);
    send_nib(0, 0, 4'h0);
    send_nib(0, 0, 4'h0);
    send_nib(0, 0, 4'h0);
    chk(ng >= ne - 1, "R8 group count", ng, ne - 1);
    for (int k = 0; k < ne && k < ng; k++)
      chk(grp[k] == expg[k], {etag[k], " (R8 R9 recovered group)"}, grp[k], expg[k]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule